// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port with Pin Resolution

This block is a 16-pin general-purpose I/O port. A simple register bus reads and writes 32-bit words. The registers cover these settings:

- pin direction,
- output driver type,
- drive speed,
- pull resistors,
- the output latch,
- an atomic set/clear word,
- a clear-only word,
- a lock word,
- two alternate-function words,
- an analog word.

Reads are combinational from the register state. Writes take effect at the clock edge.

The block also models the pins themselves. A harness outside the port can drive any pin high or low, or let it go, through a per-pin drive-enable and level pair. Each cycle the port does two things:

- It decides which of those drives it accepts. It refuses any drive that would fight its own output drivers.
- It resolves the value read back on every pin from the configuration, the output latch, the accepted drives and the pull resistors.

The resolved word appears on `pin_level` and at the input-data register address.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction (word 0), speed (word 2) and pull (word 3) registers read the values of the parameters MODE_RST, SPEED_RST and PULL_RST. The driver-type (1), input (4), output latch (5), lock (7), alternate-function (8, 9) and analog (11) words read 0, and no external drive is accepted.
- R2: Words 1, 5, 7 and 11 store only the low 16 bits. Bits 31:16 of these words always read 0.
- R3: Word 4 (input data) is read-only. A write to it changes no register and no pin value.
- R4: A write to word 6 clears latch bits whose bit in 31:16 is 1 and sets latch bits whose bit in 15:0 is 1. A set beats a clear on the same pin. Word 6 reads 0.
- R5: A write to word 10 clears latch bits whose bit in 15:0 is 1. Word 10 reads 0.
- R6: A pin is an output when its 2-bit direction field (bits 2i+1:2i) is 01. A push-pull output (driver-type bit 0) reads its latch bit. An open-drain output (driver-type bit 1) whose latch bit is 0 reads 0.
- R7: An open-drain output with latch bit 1 reads the level of an accepted external drive. With no accepted drive, it reads 1 under pull-up (pull field 01) and 0 under pull-down (pull field 10).
- R8: A non-output pin reads the level of an accepted external drive. With no accepted drive, it reads the pull value. Releasing the drive (enable 0) drops it in the same edge.
- R9: A new drive request arrives when the enable rises or the level changes while enabled. The request is refused on an output pin, unless that pin is open-drain and the requested level is 0. A refused drive stays unaccepted until its next request.
- R10: A write to words 0, 1, 3, 5, 6 or 10 drops every accepted drive on a pin that the new configuration makes an output and that is either push-pull or driven high.
- R11: A pin that has no accepted drive, no pull and no active output level keeps its previous input value.
- R12: The input value changes at the first clock edge after the write or drive change, and is visible in the cycle after it.
- R13: The speed and both alternate-function words store and read back all 32 bits with no side effect on the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| drv_en | input | 16 | External drive enable per pin |
| drv_lvl | input | 16 | External drive level per pin |
| pin_level | output | 16 | Resolved input value per pin |

## Verification
The bench aims at these corner cases:

- **Set and clear on the same pin in one write.** A design with the wrong winner leaves that latch bit at 0.
- **A drive accepted on an input that is later turned into a push-pull output and then back to input.** A design that forgets to drop the drive reads the old drive level instead of the pull value.
- **A high drive on an open-drain output under pull-down.** A design that accepts it reads 1.
- **A low drive on an open-drain output that survives a later latch write.**
- **A floating pin with no pull.** Resolving it to 0 instead of holding it shows up as a bit flip.

Random configuration writes and drive toggles are compared each cycle against a model written from the requirements.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE  = 4'd0,
        A_OTYPE = 4'd1,
        A_SPEED = 4'd2,
        A_PULL  = 4'd3,
        A_IDR   = 4'd4,
        A_ODR   = 4'd5,
        A_BSR   = 4'd6,
        A_LOCK  = 4'd7,
        A_AFL   = 4'd8,
        A_AFH   = 4'd9,
        A_BRR   = 4'd10,
        A_ANA   = 4'd11
    } reg_addr_e;

    localparam logic [1:0] DIR_OUT = 2'b01;
    localparam logic [1:0] PULL_UP = 2'b01;
    localparam logic [1:0] PULL_DN = 2'b10;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PINS = 16,
    parameter int DW   = 32,
    parameter logic [2*PINS-1:0] MODE_RST  = '1,
    parameter logic [2*PINS-1:0] SPEED_RST = '0,
    parameter logic [2*PINS-1:0] PULL_RST  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [PINS-1:0]   idr_q,
    output logic [DW-1:0]     bus_rdata,
    output logic [2*PINS-1:0] mode_d,
    output logic [2*PINS-1:0] pull_d,
    output logic [PINS-1:0]   otype_d,
    output logic [PINS-1:0]   odr_d,
    output logic              cfg_wr
);

    localparam int MW = 2 * PINS;

    typedef struct packed {
        logic [MW-1:0]   mode;
        logic [PINS-1:0] otype;
        logic [MW-1:0]   speed;
        logic [MW-1:0]   pull;
        logic [PINS-1:0] odr;
        logic [PINS-1:0] lock;
        logic [DW-1:0]   afl;
        logic [DW-1:0]   afh;
        logic [PINS-1:0] ana;
    } bank_t;

    bank_t bank_d, bank_q;
    reg_addr_e sel;

    assign sel = reg_addr_e'(bus_addr);

    always_comb begin
        bank_d = bank_q;
        cfg_wr = 1'b0;
        if (bus_wr) begin
            case (sel)
                A_MODE:  begin bank_d.mode  = bus_wdata[MW-1:0];   cfg_wr = 1'b1; end
                A_OTYPE: begin bank_d.otype = bus_wdata[PINS-1:0]; cfg_wr = 1'b1; end
                A_SPEED: bank_d.speed = bus_wdata[MW-1:0];
                A_PULL:  begin bank_d.pull  = bus_wdata[MW-1:0];   cfg_wr = 1'b1; end
                A_ODR:   begin bank_d.odr   = bus_wdata[PINS-1:0]; cfg_wr = 1'b1; end
                A_BSR: begin
                    bank_d.odr = (bank_q.odr & ~bus_wdata[PINS +: PINS]) | bus_wdata[PINS-1:0];
                    cfg_wr = 1'b1;
                end
                A_LOCK:  bank_d.lock = bus_wdata[PINS-1:0];
                A_AFL:   bank_d.afl  = bus_wdata;
                A_AFH:   bank_d.afh  = bus_wdata;
                A_BRR: begin
                    bank_d.odr = bank_q.odr & ~bus_wdata[PINS-1:0];
                    cfg_wr = 1'b1;
                end
                A_ANA:   bank_d.ana = bus_wdata[PINS-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q       <= '0;
            bank_q.mode  <= MODE_RST;
            bank_q.speed <= SPEED_RST;
            bank_q.pull  <= PULL_RST;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            A_MODE:  bus_rdata[MW-1:0]   = bank_q.mode;
            A_OTYPE: bus_rdata[PINS-1:0] = bank_q.otype;
            A_SPEED: bus_rdata[MW-1:0]   = bank_q.speed;
            A_PULL:  bus_rdata[MW-1:0]   = bank_q.pull;
            A_IDR:   bus_rdata[PINS-1:0] = idr_q;
            A_ODR:   bus_rdata[PINS-1:0] = bank_q.odr;
            A_LOCK:  bus_rdata[PINS-1:0] = bank_q.lock;
            A_AFL:   bus_rdata           = bank_q.afl;
            A_AFH:   bus_rdata           = bank_q.afh;
            A_ANA:   bus_rdata[PINS-1:0] = bank_q.ana;
            default: bus_rdata = '0;
        endcase
    end

    assign mode_d  = bank_d.mode;
    assign pull_d  = bank_d.pull;
    assign otype_d = bank_d.otype;
    assign odr_d   = bank_d.odr;

    // R4
    bsr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_BSR) |=>
        ((bank_q.odr & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0])));

    // R5
    brr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_BRR) |=>
        ((bank_q.odr & $past(bus_wdata[PINS-1:0])) == '0));

    // R3
    idr_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_IDR) |=> $stable(bank_q));

endmodule

// File: rtl/gpio_port_link.sv
module gpio_port_link #(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] drv_en,
    input  logic [PINS-1:0] drv_lvl,
    input  logic            cfg_wr,
    input  logic [PINS-1:0] out_d,
    input  logic [PINS-1:0] od_d,
    output logic [PINS-1:0] conn_d,
    output logic [PINS-1:0] hi_d,
    output logic [PINS-1:0] conn_q
);

    typedef struct packed {
        logic [PINS-1:0] conn;
        logic [PINS-1:0] hi;
        logic [PINS-1:0] en;
        logic [PINS-1:0] lvl;
    } link_t;

    link_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.en  = drv_en;
        st_d.lvl = drv_lvl;
        for (int i = 0; i < PINS; i++) begin
            if (!drv_en[i]) begin
                st_d.conn[i] = 1'b0;
            end else if (!st_q.en[i] || (drv_lvl[i] != st_q.lvl[i])) begin
                st_d.hi[i]   = drv_lvl[i];
                st_d.conn[i] = !out_d[i] || (od_d[i] && !drv_lvl[i]);
            end
            if (cfg_wr && st_d.conn[i] && out_d[i] && (!od_d[i] || st_d.hi[i])) begin
                st_d.conn[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign conn_d = st_d.conn;
    assign hi_d   = st_d.hi;
    assign conn_q = st_q.conn;

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.conn & ~$past(drv_en)) == '0));

endmodule

// File: rtl/gpio_port_resolve.sv
module gpio_port_resolve #(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] out_d,
    input  logic [PINS-1:0] od_d,
    input  logic [PINS-1:0] pu_d,
    input  logic [PINS-1:0] pd_d,
    input  logic [PINS-1:0] odr_d,
    input  logic [PINS-1:0] conn_d,
    input  logic [PINS-1:0] hi_d,
    output logic [PINS-1:0] idr_q
);

    logic [PINS-1:0] idr_d;

    always_comb begin
        idr_d = idr_q;
        for (int i = 0; i < PINS; i++) begin
            if (out_d[i] && !od_d[i]) begin
                idr_d[i] = odr_d[i];
            end else if (out_d[i] && !odr_d[i]) begin
                idr_d[i] = 1'b0;
            end else if (conn_d[i]) begin
                idr_d[i] = hi_d[i];
            end else if (pu_d[i]) begin
                idr_d[i] = 1'b1;
            end else if (pd_d[i]) begin
                idr_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idr_q <= '0;
        end else begin
            idr_q <= idr_d;
        end
    end

    // R6
    pp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(out_d & ~od_d) & (idr_q ^ $past(odr_d))) == '0));

    // R6
    od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(out_d & od_d & ~odr_d) & idr_q) == '0));

    // R11
    float_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(~conn_d & ~pu_d & ~pd_d & ~out_d) & (idr_q ^ $past(idr_q))) == '0));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int PINS = 16,
    parameter int DW   = 32,
    parameter logic [2*PINS-1:0] MODE_RST  = '1,
    parameter logic [2*PINS-1:0] SPEED_RST = 32'h0000_00F0,
    parameter logic [2*PINS-1:0] PULL_RST  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [PINS-1:0]   drv_en,
    input  logic [PINS-1:0]   drv_lvl,
    output logic [PINS-1:0]   pin_level
);

    logic [2*PINS-1:0] mode_d, pull_d;
    logic [PINS-1:0]   otype_d, odr_d;
    logic [PINS-1:0]   out_d, pu_d, pd_d;
    logic [PINS-1:0]   conn_d, hi_d, conn_q, idr_q;
    logic              cfg_wr;

    gpio_port_regs #(
        .PINS(PINS), .DW(DW),
        .MODE_RST(MODE_RST), .SPEED_RST(SPEED_RST), .PULL_RST(PULL_RST)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .idr_q(idr_q), .bus_rdata(bus_rdata),
        .mode_d(mode_d), .pull_d(pull_d), .otype_d(otype_d), .odr_d(odr_d),
        .cfg_wr(cfg_wr)
    );

    for (genvar g = 0; g < PINS; g++) begin : g_decode
        assign out_d[g] = (mode_d[2*g +: 2] == DIR_OUT);
        assign pu_d[g]  = (pull_d[2*g +: 2] == PULL_UP);
        assign pd_d[g]  = (pull_d[2*g +: 2] == PULL_DN);
    end

    gpio_port_link #(.PINS(PINS)) i_link (
        .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .drv_lvl(drv_lvl),
        .cfg_wr(cfg_wr), .out_d(out_d), .od_d(otype_d),
        .conn_d(conn_d), .hi_d(hi_d), .conn_q(conn_q)
    );

    gpio_port_resolve #(.PINS(PINS)) i_resolve (
        .clk(clk), .rst_n(rst_n), .out_d(out_d), .od_d(otype_d),
        .pu_d(pu_d), .pd_d(pd_d), .odr_d(odr_d), .conn_d(conn_d),
        .hi_d(hi_d), .idr_q(idr_q)
    );

    assign pin_level = idr_q;

    // R9
    no_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_d & out_d & (~otype_d | hi_d)) == '0);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (conn_q == '0 && idr_q == '0));

endmodule

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
    import gpio_port_pkg::*;

    localparam logic [31:0] MODE_RST  = 32'hFFFF_FFFF;
    localparam logic [31:0] SPEED_RST = 32'h0000_00F0;
    localparam logic [31:0] PULL_RST  = 32'h0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] drv_en = '0, drv_lvl = '0;
    logic [15:0] pin_level;

    int nchk = 0, nerr = 0;
    bit done = 0;

    logic [31:0] m_mode, m_speed, m_pull, m_afl, m_afh;
    logic [15:0] m_otype, m_odr, m_lock, m_ana, m_conn, m_hi, m_en, m_lvl, m_idr;
    logic [15:0] cur_en = '0, cur_lvl = '0;

    always #10 clk = ~clk;

    gpio_port #(.MODE_RST(MODE_RST), .SPEED_RST(SPEED_RST), .PULL_RST(PULL_RST)) i_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drv_en(drv_en),
        .drv_lvl(drv_lvl), .pin_level(pin_level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step(input logic wr, input logic [3:0] a, input logic [31:0] d,
                              input logic [15:0] en, input logic [15:0] lvl);
        logic cfgw, o, od;
        cfgw = 1'b0;
        if (wr) begin
            case (a)
                4'd0:  begin m_mode = d; cfgw = 1; end
                4'd1:  begin m_otype = d[15:0]; cfgw = 1; end
                4'd2:  m_speed = d;
                4'd3:  begin m_pull = d; cfgw = 1; end
                4'd5:  begin m_odr = d[15:0]; cfgw = 1; end
                4'd6:  begin m_odr = (m_odr & ~d[31:16]) | d[15:0]; cfgw = 1; end
                4'd7:  m_lock = d[15:0];
                4'd8:  m_afl = d;
                4'd9:  m_afh = d;
                4'd10: begin m_odr = m_odr & ~d[15:0]; cfgw = 1; end
                4'd11: m_ana = d[15:0];
                default: ;
            endcase
        end
        for (int i = 0; i < 16; i++) begin
            o  = (m_mode[2*i +: 2] == 2'b01);
            od = m_otype[i];
            if (!en[i]) m_conn[i] = 0;
            else if (!m_en[i] || lvl[i] != m_lvl[i]) begin
                m_hi[i] = lvl[i];
                m_conn[i] = !o || (od && !lvl[i]);
            end
            if (cfgw && m_conn[i] && o && (!od || m_hi[i])) m_conn[i] = 0;
            if (o && !od) m_idr[i] = m_odr[i];
            else if (o && !m_odr[i]) m_idr[i] = 0;
            else if (m_conn[i]) m_idr[i] = m_hi[i];
            else if (m_pull[2*i +: 2] == 2'b01) m_idr[i] = 1;
            else if (m_pull[2*i +: 2] == 2'b10) m_idr[i] = 0;
        end
        m_en = en;
        m_lvl = lvl;
    endtask

    task automatic cyc(input logic wr, input logic [3:0] a, input logic [31:0] d,
                       input logic [15:0] en, input logic [15:0] lvl);
        bus_wr = wr; bus_addr = a; bus_wdata = d; drv_en = en; drv_lvl = lvl;
        cur_en = en; cur_lvl = lvl;
        model_step(wr, a, d, en, lvl);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R12 pin_level vs model", {16'h0, pin_level}, {16'h0, m_idr});
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, cur_en, cur_lvl);
    endtask

    task automatic drv(input logic [15:0] en, input logic [15:0] lvl);
        cyc(1'b0, 4'd0, 32'h0, en, lvl);
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic bit3(input logic exp, input string tag);
        chk(tag, {31'h0, pin_level[3]}, {31'h0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_mode = MODE_RST; m_speed = SPEED_RST; m_pull = PULL_RST;
        m_afl = 0; m_afh = 0; m_otype = 0; m_odr = 0; m_lock = 0; m_ana = 0;
        m_conn = 0; m_hi = 0; m_en = 0; m_lvl = 0; m_idr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(4'd0, MODE_RST, "R1 mode");
        rd(4'd2, SPEED_RST, "R1 speed");
        rd(4'd3, PULL_RST, "R1 pull");
        rd(4'd1, 0, "R1 otype");
        rd(4'd4, 0, "R1 idr");
        rd(4'd5, 0, "R1 odr");
        rd(4'd7, 0, "R1 lock");
        rd(4'd8, 0, "R1 afl");
        rd(4'd11, 0, "R1 analog");
        chk("R1 pin_level", {16'h0, pin_level}, 32'h0);

        // R2 masked upper halves
        wr(4'd5, 32'hFFFF_FFFF); rd(4'd5, 32'h0000_FFFF, "R2 odr");
        wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, 32'h0000_FFFF, "R2 otype");
        wr(4'd7, 32'hFFFF_FFFF); rd(4'd7, 32'h0000_FFFF, "R2 lock");
        wr(4'd11, 32'hFFFF_FFFF); rd(4'd11, 32'h0000_FFFF, "R2 analog");
        wr(4'd1, 32'h0);

        // R13 plain storage
        wr(4'd2, 32'h1234_5678); rd(4'd2, 32'h1234_5678, "R13 speed");
        wr(4'd8, 32'hA5A5_0F0F); rd(4'd8, 32'hA5A5_0F0F, "R13 afl");
        wr(4'd9, 32'h5A5A_F0F0); rd(4'd9, 32'h5A5A_F0F0, "R13 afh");

        // R3 read-only input word
        wr(4'd5, 32'h0000_0002);
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd4, {16'h0, m_idr}, "R3 idr unchanged");
        rd(4'd5, 32'h0000_0002, "R3 odr unchanged");

        // R4 set wins, R5 clear-only
        wr(4'd6, 32'h0003_0005); rd(4'd5, 32'h0000_0005, "R4 set/clear");
        rd(4'd6, 32'h0, "R4 reads zero");
        wr(4'd10, 32'h0000_0004); rd(4'd5, 32'h0000_0001, "R5 clear");
        rd(4'd10, 32'h0, "R5 reads zero");
        wr(4'd5, 32'h0);

        // Pin 3 directed scenario
        drv(16'h8, 16'h8);            bit3(1, "R8 input follows drive high");
        drv(16'h0, 16'h0);            bit3(1, "R11 floating keeps value");
        wr(4'd3, 32'h80);             bit3(0, "R8 pull-down");
        drv(16'h8, 16'h8);            bit3(1, "R8 drive over pull");
        wr(4'd0, 32'hFFFF_FF7F);      bit3(0, "R6 push-pull reads latch");
        wr(4'd0, 32'hFFFF_FFFF);      bit3(0, "R10 drive dropped on push-pull");
        drv(16'h0, 16'h0);
        wr(4'd1, 32'h8);
        wr(4'd6, 32'h8);
        wr(4'd0, 32'hFFFF_FF7F);      bit3(0, "R7 open-drain pull-down");
        wr(4'd3, 32'h40);             bit3(1, "R7 open-drain pull-up");
        wr(4'd3, 32'h80);
        drv(16'h8, 16'h8);            bit3(0, "R9 high drive refused");
        wr(4'd0, 32'hFFFF_FFFF);      bit3(0, "R9 refusal persists");
        drv(16'h0, 16'h0);
        wr(4'd0, 32'hFFFF_FF7F);
        wr(4'd3, 32'h40);             bit3(1, "R7 pull-up again");
        drv(16'h8, 16'h0);            bit3(0, "R7 accepted low drive");
        wr(4'd5, 32'h8);              bit3(0, "R10 low open-drain drive kept");
        wr(4'd1, 32'h0);              bit3(1, "R10 push-pull drops drive");
        wr(4'd1, 32'h8);              bit3(1, "R7 disconnected uses pull-up");
        wr(4'd10, 32'h8);             bit3(0, "R6 open-drain latch zero");

        // R12 timing on pin 0
        wr(4'd0, 32'hFFFF_FF7D);
        bus_wr = 1; bus_addr = 4'd6; bus_wdata = 32'h1;
        #1;
        chk("R12 not before edge", {31'h0, pin_level[0]}, 32'h0);
        model_step(1'b1, 4'd6, 32'h1, cur_en, cur_lvl);
        @(posedge clk); @(negedge clk);
        bus_wr = 0;
        chk("R12 visible after edge", {31'h0, pin_level[0]}, 32'h1);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [31:0] r;
            op = $urandom % 9;
            r = $urandom;
            case (op)
                0: wr(4'd0, r);
                1: wr(4'd1, r);
                2: wr(4'd3, r);
                3: wr(4'd5, r);
                4: wr(4'd6, r);
                5: wr(4'd10, r);
                6: wr(4'd4, r);
                default: drv(cur_en ^ (16'h1 << (r % 16)), cur_lvl ^ (r[31:16] & r[15:0]));
            endcase
            if ((n % 10) == 0) begin
                rd(4'd5, {16'h0, m_odr}, "R4 random latch");
                rd(4'd4, {16'h0, m_idr}, "R3 random input word");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule